// File: doc/BRIEF.md
# Demand-Driven Paired Traffic Light Controller

This block controls the lamps of a crossing where four roads meet. Roads 1 and 3 form pair A and move together. Roads 2 and 4 form pair B and also move together. A 4-bit vehicle-presence input reports which roads have waiting traffic. While no phase is running, the controller sits in an all-red rest state. It starts a green phase only for a pair that has demand. When both pairs have demand at the same time, pair A is served.

A running phase is timed by an internal down-counter. The counter is loaded with a green length or an amber length, and it raises a one-cycle done pulse when it reaches zero. Each amber phase always returns to the all-red rest state, and the next pair is chosen again from the demand seen there. The sequence is therefore driven by demand and does not rotate through the pairs in a fixed order. A 3-bit phase code is brought out so the current state can be observed.

Top module: `tl_pair_ctrl`

## Requirements
- R1: Bit i of `veh_present` belongs to road i+1. Bit i of `lamp_red`, `lamp_green` and `lamp_amber` drives that same road. Pair A is the mask 4'b0101 and pair B is the mask 4'b1010.
- R2: While `rst` is high at a clock edge, the next state is the rest state. In that state `phase_code` is 0, `lamp_red` is 4'b1111, and `lamp_green` and `lamp_amber` are zero.
- R3: In the rest state, demand on road 1 or road 3 moves the controller to pair A green (`phase_code` 1) at the next edge.
- R4: In the rest state, demand only on road 2 and/or road 4 moves the controller to pair B green (`phase_code` 3) at the next edge.
- R5: When both pairs have demand in the rest state, pair A green is chosen.
- R6: In the rest state with no demand, the controller stays in the rest state and the counter holds its value.
- R7: A green phase lasts GREEN_CYC+1 cycles. It then becomes the amber phase of the same pair (`phase_code` 2 for A, 4 for B). The done pulse is high for one cycle only.
- R8: An amber phase lasts AMBER_CYC+1 cycles. It then returns to the rest state (`phase_code` 0).
- R9: During green or amber of one pair, that pair's two roads show the active colour and the other pair's two roads show red.
- R10: On every road, exactly one of red, green or amber is lit at all times.
- R11: Changes on `veh_present` during a green or amber phase do not change the length or order of the phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| veh_present | input | 4 | Vehicle presence per road (bit 0 = road 1) |
| lamp_red | output | 4 | Red lamps per road |
| lamp_green | output | 4 | Green lamps per road |
| lamp_amber | output | 4 | Amber lamps per road |
| phase_code | output | 3 | Current state: 0 rest, 1 A green, 2 A amber, 3 B green, 4 B amber |

## Verification
The bench counts the exact number of cycles that each green and each amber phase is visible. A design whose counter is off by one shows a phase that is one cycle too long or too short. Demand on both pairs, and demand on a single road of each pair, checks the priority and the bit mapping: a design that swaps the pairs or has a wrong bit mask lights the wrong roads. Demand is changed during the timed phases, so a controller that re-arbitrates or reloads its counter in the middle of a phase would show a changed duration. Holding demand across the end of amber shows whether the rest state lasts exactly one cycle.

// File: rtl/tl_pkg.sv
package tl_pkg;

    typedef enum logic [2:0] {
        PH_REST  = 3'd0,
        PH_GO_A  = 3'd1,
        PH_AMB_A = 3'd2,
        PH_GO_B  = 3'd3,
        PH_AMB_B = 3'd4
    } phase_t;

    typedef struct packed {
        logic [3:0] red;
        logic [3:0] grn;
        logic [3:0] amb;
    } lamps_t;

    localparam int          ROADS  = 4;
    localparam logic [3:0]  PAIR_A = 4'b0101;
    localparam logic [3:0]  PAIR_B = 4'b1010;

    function automatic logic is_green(phase_t p);
        return (p == PH_GO_A) || (p == PH_GO_B);
    endfunction

    function automatic logic is_timed(phase_t p);
        return p != PH_REST;
    endfunction

endpackage

// File: rtl/tl_pick.sv
module tl_pick
    import tl_pkg::*;
(
    input  logic [ROADS-1:0] veh,
    output phase_t           pick
);
    logic want_a, want_b;

    assign want_a = |(veh & PAIR_A);
    assign want_b = |(veh & PAIR_B);

    always_comb begin
        if (want_a)      pick = PH_GO_A;
        else if (want_b) pick = PH_GO_B;
        else             pick = PH_REST;
    end
endmodule

// File: rtl/tl_countdown.sv
module tl_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (run && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = run && (cnt == '0);

    // R7: the count steps down by one per cycle inside a timed phase
    p_step_down_r7: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/tl_lamps.sv
module tl_lamps
    import tl_pkg::*;
(
    input  phase_t ph,
    output lamps_t lamps
);
    logic a_on, b_on, green_ph;

    assign a_on     = (ph == PH_GO_A) || (ph == PH_AMB_A);
    assign b_on     = (ph == PH_GO_B) || (ph == PH_AMB_B);
    assign green_ph = is_green(ph);

    for (genvar i = 0; i < ROADS; i++) begin : g_road
        logic moving;
        assign moving       = PAIR_A[i] ? a_on : b_on;
        assign lamps.red[i] = !moving;
        assign lamps.grn[i] = moving && green_ph;
        assign lamps.amb[i] = moving && !green_ph;
    end
endmodule

// File: rtl/tl_pair_ctrl.sv
module tl_pair_ctrl
    import tl_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int GREEN_CYC = 55,
    parameter int AMBER_CYC = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROADS-1:0] veh_present,
    output logic [ROADS-1:0] lamp_red,
    output logic [ROADS-1:0] lamp_green,
    output logic [ROADS-1:0] lamp_amber,
    output logic [2:0]       phase_code
);
    localparam logic [CNT_W-1:0] GREEN_LD = CNT_W'(GREEN_CYC);
    localparam logic [CNT_W-1:0] AMBER_LD = CNT_W'(AMBER_CYC);

    phase_t           ph, ph_nxt, pick;
    lamps_t           lamps;
    logic             load, run, done;
    logic [CNT_W-1:0] load_val, cnt;

    tl_pick u_pick (.veh(veh_present), .pick(pick));

    always_comb begin
        ph_nxt = ph;
        unique case (ph)
            PH_REST:  ph_nxt = pick;
            PH_GO_A:  if (done) ph_nxt = PH_AMB_A;
            PH_AMB_A: if (done) ph_nxt = PH_REST;
            PH_GO_B:  if (done) ph_nxt = PH_AMB_B;
            PH_AMB_B: if (done) ph_nxt = PH_REST;
            default:  ph_nxt = PH_REST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_REST;
        else     ph <= ph_nxt;
    end

    assign run      = is_timed(ph);
    assign load     = (ph_nxt != ph) && is_timed(ph_nxt);
    assign load_val = is_green(ph_nxt) ? GREEN_LD : AMBER_LD;

    tl_countdown #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .run(run), .cnt(cnt), .done(done)
    );

    tl_lamps u_lamps (.ph(ph), .lamps(lamps));

    assign lamp_red   = lamps.red;
    assign lamp_green = lamps.grn;
    assign lamp_amber = lamps.amb;
    assign phase_code = ph;

    // R5 / R3: pair A demand from rest wins
    p_pair_a_first_r5: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_REST && |(veh_present & PAIR_A)) |=> (phase_code == 3'd1));

    // R4: pair B alone from rest
    p_pair_b_only_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_REST && !(|(veh_present & PAIR_A)) && |(veh_present & PAIR_B))
        |=> (phase_code == 3'd3));

    // R6: no demand keeps rest and freezes the counter
    p_rest_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_REST && veh_present == '0) |=> (phase_code == 3'd0 && $stable(cnt)));

    // R7: a green start loads the green length
    p_green_load_r7: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_REST && veh_present != '0) |=> (cnt == GREEN_LD));

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: amber ends in rest
    p_amber_exit_r8: assert property (@(posedge clk) disable iff (rst)
        ((ph == PH_AMB_A || ph == PH_AMB_B) && done) |=> (phase_code == 3'd0));

    // R10: one lamp per road
    for (genvar i = 0; i < ROADS; i++) begin : g_chk
        p_one_lamp_r10: assert property (@(posedge clk) disable iff (rst)
            $countones({lamp_red[i], lamp_green[i], lamp_amber[i]}) == 1);
    end
endmodule

// File: tb/test_tl_pair_ctrl.sv
module test_tl_pair_ctrl;
    localparam int GREEN_CYC = 55;
    localparam int AMBER_CYC = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] veh_present = 4'b0000;
    logic [3:0] lamp_red, lamp_green, lamp_amber;
    logic [2:0] phase_code;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tl_pair_ctrl #(.GREEN_CYC(GREEN_CYC), .AMBER_CYC(AMBER_CYC)) i_tl_pair_ctrl (
        .clk(clk), .rst(rst), .veh_present(veh_present),
        .lamp_red(lamp_red), .lamp_green(lamp_green), .lamp_amber(lamp_amber),
        .phase_code(phase_code)
    );

    // vector: {demand at start, demand during phases, expected green code}
    typedef struct packed {
        logic [3:0] start_d;
        logic [3:0] mid_d;
        logic [2:0] go_code;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 4'b0000, 3'd1},  // R3 road 1
        '{4'b0100, 4'b1010, 3'd1},  // R3 road 3, R11 other demand mid
        '{4'b0010, 4'b0101, 3'd3},  // R4 road 2, R11
        '{4'b1000, 4'b0000, 3'd3},  // R4 road 4
        '{4'b1111, 4'b0000, 3'd1},  // R5 all roads
        '{4'b1010, 4'b1111, 3'd3},  // R4 both B roads, R11
        '{4'b0101, 4'b1010, 3'd1},  // R3 both A roads
        '{4'b0011, 4'b0000, 3'd1}   // R5 mixed
    };

    function automatic logic [11:0] exp_lamps(input logic [2:0] code);
        case (code)
            3'd1:    return {4'b1010, 4'b0101, 4'b0000};
            3'd2:    return {4'b1010, 4'b0000, 4'b0101};
            3'd3:    return {4'b0101, 4'b1010, 4'b0000};
            3'd4:    return {4'b0101, 4'b0000, 4'b1010};
            default: return {4'b1111, 4'b0000, 4'b0000};
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_lamps(input string tag, input logic [2:0] code);
        chk(tag, int'({lamp_red, lamp_green, lamp_amber}), int'(exp_lamps(code)));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // run one full served phase from rest; returns with controller back in rest
    task automatic serve(input vec_t v);
        int n;
        veh_present = v.start_d;
        step();
        chk("R3/R4/R5 green code", phase_code, v.go_code);
        chk_lamps("R1/R9 green lamps", v.go_code);
        veh_present = v.mid_d;
        n = 1;
        while (phase_code == v.go_code && n < 200) begin
            step();
            n++;
        end
        n--;
        chk("R7/R11 green length", n, GREEN_CYC + 1);
        chk("R7 amber code", phase_code, v.go_code + 3'd1);
        chk_lamps("R9 amber lamps", v.go_code + 3'd1);
        n = 1;
        while (phase_code == v.go_code + 3'd1 && n < 200) begin
            step();
            n++;
        end
        n--;
        chk("R8/R11 amber length", n, AMBER_CYC + 1);
        chk("R8 back to rest", phase_code, 0);
        chk_lamps("R10 rest lamps", 3'd0);
        veh_present = 4'b0000;
    endtask

    initial begin
        #150000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        chk("R2 reset code", phase_code, 0);
        chk_lamps("R2 reset lamps", 3'd0);
        // demand while reset is held is ignored
        veh_present = 4'b1111;
        step();
        chk("R2 reset overrides demand", phase_code, 0);
        veh_present = 4'b0000;
        rst = 1'b0;

        // R6: no demand, rest is held
        for (int k = 0; k < 5; k++) step();
        chk("R6 rest held", phase_code, 0);
        chk_lamps("R6 rest lamps", 3'd0);

        for (int i = 0; i < NV; i++) begin
            serve(VECS[i]);
            step();
            chk("R6 rest after serve", phase_code, 0);
        end

        // steady demand: rest lasts exactly one cycle between phases
        veh_present = 4'b0010;
        step();
        chk("R4 steady demand green", phase_code, 3);
        for (int k = 0; k < GREEN_CYC + AMBER_CYC + 2; k++) step();
        chk("R8 single rest cycle", phase_code, 0);
        step();
        chk("R4 green again", phase_code, 3);
        chk_lamps("R1 B green lamps", 3'd3);

        // reset in the middle of a green phase
        rst = 1'b1;
        step();
        rst = 1'b0;
        veh_present = 4'b0000;
        chk("R2 mid-phase reset", phase_code, 0);
        chk_lamps("R2 mid-phase reset lamps", 3'd0);
        step();
        chk("R6 rest after reset", phase_code, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule